// File: doc/BRIEF.md
# Integer Load Address and Writeback Unit

This unit runs the zero-extending byte and half-word integer loads of a 32-bit big-endian core. It takes one decoded load per handshake: the access size, the address form (base plus signed displacement, or base plus index register), an update flag, the base, index and destination register numbers, and the base and index register contents. It forms the effective address and issues one read of the aligned word on a valid/ready memory port. When the response word comes back, it picks the addressed byte or half-word, clears the upper bits, and presents the register-file writes.

Only one load is in flight at a time. The unit shows `busy` from the cycle after acceptance until the write-back cycle. In that cycle it pulses `done` together with the write strobes. Update forms also return the effective address on a second write port. The update cases that the architecture leaves undefined are given fixed results here. A base number of zero still has its address written to register 0. A base equal to the destination gives the loaded data to that register.

Top module: `intld_unit`

## Requirements
- R1: In displacement form (`opIndexed`=0) the effective address is B + sign-extended `opDisp`, taken modulo 2^32. B is zero when `opIdxA` is 0 and `opValA` otherwise.
- R2: In indexed form (`opIndexed`=1) the effective address is B + `opValB` modulo 2^32, with the same zero substitution for B.
- R3: `memAddr` carries the effective address with bits 1:0 cleared. `memReqValid` rises the cycle after acceptance and stays high with `memAddr` stable until the cycle in which `memReqReady` is sampled high.
- R4: A byte load (`opHalf`=0) writes to rD the byte at lane EA[1:0] of the response word, zero-extended. Lane 0 is bits 31:24 and lane 3 is bits 7:0.
- R5: A half-word load (`opHalf`=1) writes to rD the zero-extended half-word in bits 31:16 when EA[1]=0, or in bits 15:0 when EA[1]=1.
- R6: An update load (`opUpdate`=1) whose rA differs from rD writes the effective address on the A port in the same cycle as the rD write.
- R7: An update load with `opIdxA`=0 still enables the A port, with index 0 and the effective address. That address was computed with a zero base.
- R8: When an update load has rA equal to rD, only the D port is enabled, and it carries the memory data.
- R9: A non-update load never enables the A port, whatever `opIdxA` is.
- R10: `opReady` is high only while idle. `busy` is high from the cycle after acceptance through the write-back cycle. `done` is high for exactly the write-back cycle, one cycle after the response is sampled. `wrDEn` is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Load operation offered |
| opReady | output | 1 | Unit idle, operation accepted when opValid is high |
| opHalf | input | 1 | 1: half-word, 0: byte |
| opIndexed | input | 1 | 1: base plus index register, 0: base plus displacement |
| opUpdate | input | 1 | Write effective address back to rA |
| opIdxA | input | 5 | Base register number |
| opIdxD | input | 5 | Destination register number |
| opValA | input | 32 | Base register contents |
| opValB | input | 32 | Index register contents |
| opDisp | input | 16 | Signed displacement |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts request |
| memAddr | output | 32 | Word-aligned read address |
| memRspValid | input | 1 | Response word valid |
| memRspData | input | 32 | Big-endian response word |
| wrDEn | output | 1 | Destination write enable |
| wrDIdx | output | 5 | Destination register number |
| wrDData | output | 32 | Zero-extended load data |
| wrAEn | output | 1 | Base write enable |
| wrAIdx | output | 5 | Base register number |
| wrAData | output | 32 | Effective address |
| busy | output | 1 | Load in progress |
| done | output | 1 | Write-back cycle strobe |

## Verification
The bench targets the zero-base substitution with a nonzero value on the base input. A design that read the register value there would issue the wrong address. It drives every byte lane and both half-word lanes. A lane-order slip would return a neighbour's data, and a missing clear would leak upper response bits into rD. It covers the base-equals-destination update, where a design that let the address write win would enable the A port or put the address on D. It also covers the register-0 update, where a design that suppressed the write would leave `wrAEn` low. Address wrap-around, negative displacements and a stalled request are included, so a design that dropped the carry, zero-extended the displacement or changed the address during a stall would be caught.

// File: rtl/intld_pkg.sv
package intld_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_WB   = 2'd3
  } ldState_e;

  typedef struct packed {
    logic capOp;   // latch operation and effective address
    logic capRsp;  // latch memory response word
    logic wbEn;    // present register-file writes
  } ldCtrl_t;

endpackage

// File: rtl/intld_ctrl.sv
module intld_ctrl
  import intld_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output ldCtrl_t ctrl,
  output logic    opReady,
  output logic    memReqValid,
  output logic    busy,
  output logic    done
);

  ldState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (opValid)     stateNext = ST_REQ;
      ST_REQ:  if (memReqReady) stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_WB;
      ST_WB:                    stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl        = '0;
    ctrl.capOp  = (state == ST_IDLE) && opValid;
    ctrl.capRsp = (state == ST_WAIT) && memRspValid;
    ctrl.wbEn   = (state == ST_WB);
  end

  assign opReady     = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_WB);

endmodule

// File: rtl/intld_dpath.sv
module intld_dpath
  import intld_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ldCtrl_t          ctrl,
  input  logic             opHalf,
  input  logic             opIndexed,
  input  logic             opUpdate,
  input  logic [IDX_W-1:0] opIdxA,
  input  logic [IDX_W-1:0] opIdxD,
  input  logic [XLEN-1:0]  opValA,
  input  logic [XLEN-1:0]  opValB,
  input  logic [DISP_W-1:0] opDisp,
  input  logic [XLEN-1:0]  memRspData,
  output logic [XLEN-1:0]  memAddr,
  output logic             wrDEn,
  output logic [IDX_W-1:0] wrDIdx,
  output logic [XLEN-1:0]  wrDData,
  output logic             wrAEn,
  output logic [IDX_W-1:0] wrAIdx,
  output logic [XLEN-1:0]  wrAData
);

  localparam int LANES  = XLEN / 8;
  localparam int HALVES = LANES / 2;
  localparam int LSEL_W = $clog2(LANES);
  localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic             halfQ, updateQ;
  logic [IDX_W-1:0] idxAQ, idxDQ;
  logic [XLEN-1:0]  eaQ, wordQ;

  logic [XLEN-1:0] baseVal, offsetVal, eaNext;

  always_comb begin
    baseVal   = (opIdxA == '0) ? '0 : opValA;
    offsetVal = opIndexed ? opValB
                          : {{(XLEN-DISP_W){opDisp[DISP_W-1]}}, opDisp};
    eaNext    = baseVal + offsetVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfQ   <= 1'b0;
      updateQ <= 1'b0;
      idxAQ   <= '0;
      idxDQ   <= '0;
      eaQ     <= '0;
      wordQ   <= '0;
    end else begin
      if (ctrl.capOp) begin
        halfQ   <= opHalf;
        updateQ <= opUpdate;
        idxAQ   <= opIdxA;
        idxDQ   <= opIdxD;
        eaQ     <= eaNext;
      end
      if (ctrl.capRsp) wordQ <= memRspData;
    end
  end

  // big-endian lane split: lane 0 is the most significant byte
  logic [7:0]  byteLane [LANES];
  logic [15:0] halfLane [HALVES];

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign byteLane[i] = wordQ[XLEN-1-8*i -: 8];
  end
  for (genvar j = 0; j < HALVES; j++) begin : g_half
    assign halfLane[j] = wordQ[XLEN-1-16*j -: 16];
  end

  logic [LSEL_W-1:0] byteSel;
  logic [HSEL_W-1:0] halfSel;
  logic [7:0]        byteVal;
  logic [15:0]       halfVal;

  always_comb begin
    byteSel = eaQ[LSEL_W-1:0];
    halfSel = HSEL_W'(eaQ[LSEL_W-1:1]);
    byteVal = byteLane[byteSel];
    halfVal = halfLane[halfSel];
  end

  logic idxClash;
  assign idxClash = (idxAQ == idxDQ);

  assign memAddr = {eaQ[XLEN-1:LSEL_W], {LSEL_W{1'b0}}};
  assign wrDEn   = ctrl.wbEn;
  assign wrDIdx  = idxDQ;
  assign wrDData = halfQ ? {{(XLEN-16){1'b0}}, halfVal}
                         : {{(XLEN-8){1'b0}}, byteVal};
  assign wrAEn   = ctrl.wbEn && updateQ && !idxClash;
  assign wrAIdx  = idxAQ;
  assign wrAData = eaQ;

endmodule

// File: rtl/intld_unit.sv
module intld_unit
  import intld_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 5,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic              opHalf,
  input  logic              opIndexed,
  input  logic              opUpdate,
  input  logic [IDX_W-1:0]  opIdxA,
  input  logic [IDX_W-1:0]  opIdxD,
  input  logic [XLEN-1:0]   opValA,
  input  logic [XLEN-1:0]   opValB,
  input  logic [DISP_W-1:0] opDisp,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [XLEN-1:0]   memAddr,
  input  logic              memRspValid,
  input  logic [XLEN-1:0]   memRspData,
  output logic              wrDEn,
  output logic [IDX_W-1:0]  wrDIdx,
  output logic [XLEN-1:0]   wrDData,
  output logic              wrAEn,
  output logic [IDX_W-1:0]  wrAIdx,
  output logic [XLEN-1:0]   wrAData,
  output logic              busy,
  output logic              done
);

  ldCtrl_t ctrl;

  intld_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .ctrl        (ctrl),
    .opReady     (opReady),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done)
  );

  intld_dpath #(
    .XLEN   (XLEN),
    .IDX_W  (IDX_W),
    .DISP_W (DISP_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opHalf     (opHalf),
    .opIndexed  (opIndexed),
    .opUpdate   (opUpdate),
    .opIdxA     (opIdxA),
    .opIdxD     (opIdxD),
    .opValA     (opValA),
    .opValB     (opValB),
    .opDisp     (opDisp),
    .memRspData (memRspData),
    .memAddr    (memAddr),
    .wrDEn      (wrDEn),
    .wrDIdx     (wrDIdx),
    .wrDData    (wrDData),
    .wrAEn      (wrAEn),
    .wrAIdx     (wrAIdx),
    .wrAData    (wrAData)
  );

endmodule

// File: rtl/intld_unit_chk.sv
module intld_unit_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             opReady,
  input logic             memReqValid,
  input logic             memReqReady,
  input logic [XLEN-1:0]  memAddr,
  input logic             memRspValid,
  input logic             wrDEn,
  input logic [IDX_W-1:0] wrDIdx,
  input logic             wrAEn,
  input logic [IDX_W-1:0] wrAIdx,
  input logic             busy,
  input logic             done
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr)); // R3

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memAddr[1:0] == 2'b00); // R3

  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    opValid && opReady |=> memReqValid && busy); // R3

  AST_NO_CLASH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrAEn |-> wrAIdx != wrDIdx); // R8

  AST_A_WITH_D: assert property (@(posedge clk) disable iff (!rstN)
    wrAEn |-> wrDEn); // R6

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !opReady); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R10

  AST_WB_AFTER_RSP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(memRspValid)); // R10

  AST_WRITE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    wrDEn |-> done); // R10

endmodule

bind intld_unit intld_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/intld_unit_tb_top.sv
module intld_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid, opReady, opHalf, opIndexed, opUpdate;
  logic [4:0]  opIdxA, opIdxD;
  logic [31:0] opValA, opValB;
  logic [15:0] opDisp;
  logic        memReqValid, memReqReady;
  logic [31:0] memAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        wrDEn, wrAEn, busy, done;
  logic [4:0]  wrDIdx, wrAIdx;
  logic [31:0] wrDData, wrAData;

  always #2.5 clk = ~clk;  // 200 MHz

  intld_unit dut_i (.*);

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state: expected phase of the unit
  bit expBusy = 0;
  bit expWb   = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[9:2] ^ 8'hA5, a[17:10] ^ 8'h3C, a[25:18] ^ 8'hF0, a[31:26], 2'b01} ^ 32'h9E37_79B1;
  endfunction

  // every-clock comparison against the model phase
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy == expBusy, "R10 busy", {31'd0, busy}, {31'd0, expBusy});
      check(wrDEn == expWb, "R10 wrDEn", {31'd0, wrDEn}, {31'd0, expWb});
      check(done == expWb, "R10 done", {31'd0, done}, {31'd0, expWb});
      check(opReady == !expBusy, "R10 opReady", {31'd0, opReady}, {31'd0, !expBusy});
      if (!expWb) check(!wrAEn, "R9 wrAEn idle", {31'd0, wrAEn}, 32'd0);
    end
  end

  task automatic runOp(input bit half, input bit indexed, input bit upd,
                       input logic [4:0] ia, input logic [4:0] id,
                       input logic [31:0] va, input logic [31:0] vb,
                       input logic [15:0] d, input int reqStall, input int rspStall);
    logic [31:0] ea, word, expD;
    bit expA;
    ea = ((ia == 5'd0) ? 32'd0 : va) + (indexed ? vb : {{16{d[15]}}, d});
    word = memWord({ea[31:2], 2'b00});
    if (half) expD = ea[1] ? {16'd0, word[15:0]} : {16'd0, word[31:16]};
    else      expD = {24'd0, word[8*(3-ea[1:0]) +: 8]};
    expA = upd && (ia != id);

    @(negedge clk);
    opValid = 1; opHalf = half; opIndexed = indexed; opUpdate = upd;
    opIdxA = ia; opIdxD = id; opValA = va; opValB = vb; opDisp = d;
    @(posedge clk);
    expBusy = 1;
    @(negedge clk);
    opValid = 0; opValA = 32'hDEAD_BEEF; opValB = 32'hDEAD_BEEF;
    check(memReqValid, "R3 reqValid", {31'd0, memReqValid}, 32'd1);
    check(memAddr == {ea[31:2], 2'b00}, indexed ? "R2 addr" : "R1 addr",
          memAddr, {ea[31:2], 2'b00});
    for (int k = 0; k < reqStall; k++) begin
      @(negedge clk);
      check(memReqValid && memAddr == {ea[31:2], 2'b00}, "R3 hold", memAddr,
            {ea[31:2], 2'b00});
    end
    memReqReady = 1;
    @(negedge clk);
    memReqReady = 0;
    check(!memReqValid, "R3 drop", {31'd0, memReqValid}, 32'd0);
    for (int k = 0; k < rspStall; k++) @(negedge clk);
    memRspValid = 1; memRspData = word;
    @(posedge clk);
    expWb = 1;
    @(negedge clk);
    memRspValid = 0; memRspData = 32'h5555_AAAA;
    check(wrDIdx == id, "R10 wrDIdx", {27'd0, wrDIdx}, {27'd0, id});
    check(wrDData == expD, half ? "R5 data" : "R4 data", wrDData, expD);
    check(wrAEn == expA, upd ? (ia == id ? "R8 clash" : (ia == 0 ? "R7 r0" : "R6 upd"))
                             : "R9 noupd", {31'd0, wrAEn}, {31'd0, expA});
    if (expA) begin
      check(wrAIdx == ia, "R6 wrAIdx", {27'd0, wrAIdx}, {27'd0, ia});
      check(wrAData == ea, ia == 0 ? "R7 ea" : "R6 ea", wrAData, ea);
    end
    @(posedge clk);
    expWb = 0; expBusy = 0;
  endtask

  initial begin
    rstN = 0; opValid = 0; opHalf = 0; opIndexed = 0; opUpdate = 0;
    opIdxA = 0; opIdxD = 0; opValA = 0; opValB = 0; opDisp = 0;
    memReqReady = 0; memRspValid = 0; memRspData = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && opReady && !memReqValid && !wrDEn && !wrAEn && !done,
          "R10 reset", {27'd0, busy, opReady, memReqValid, wrDEn, done}, 32'h8);
    rstN = 1;

    // R4: all four byte lanes, displacement form
    for (int l = 0; l < 4; l++)
      runOp(0, 0, 0, 5'd3, 5'd7, 32'h0001_0000, 32'h0, 16'(l), l, 1);
    // R1: negative displacement, zero base substituted (R0 value ignored)
    runOp(0, 0, 0, 5'd0, 5'd9, 32'h1234_5678, 32'h0, 16'hFFF5, 0, 0);
    // R1: wrap-around past 2^32
    runOp(1, 0, 0, 5'd4, 5'd5, 32'hFFFF_FFF0, 32'h0, 16'h0022, 2, 0);
    // R5: both half-word lanes
    runOp(1, 0, 0, 5'd2, 5'd8, 32'h0000_8000, 32'h0, 16'h0000, 0, 2);
    runOp(1, 0, 0, 5'd2, 5'd8, 32'h0000_8000, 32'h0, 16'h0002, 1, 0);
    // R2: indexed form, and with zero base
    runOp(0, 1, 0, 5'd6, 5'd1, 32'h4000_0001, 32'h0000_0102, 16'h7FFF, 0, 0);
    runOp(1, 1, 0, 5'd0, 5'd1, 32'hFFFF_FFFF, 32'h0000_0246, 16'h0, 0, 3);
    // R6: update, distinct indices
    runOp(0, 0, 1, 5'd10, 5'd11, 32'h0020_0000, 32'h0, 16'h0013, 1, 1);
    runOp(1, 1, 1, 5'd12, 5'd13, 32'h0030_0000, 32'h0000_0A0A, 16'h0, 0, 0);
    // R7: update with base index 0
    runOp(0, 0, 1, 5'd0, 5'd14, 32'hABCD_0000, 32'h0, 16'h0101, 0, 0);
    // R8: update with rA equal to rD
    runOp(1, 0, 1, 5'd15, 5'd15, 32'h0050_0000, 32'h0, 16'h0006, 0, 1);
    runOp(0, 1, 1, 5'd20, 5'd20, 32'h0060_0000, 32'h0000_0003, 16'h0, 2, 0);
    // R9: non-update with nonzero base index
    runOp(0, 0, 0, 5'd21, 5'd22, 32'h0070_0000, 32'h0, 16'h0001, 0, 0);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule